// File: doc/BRIEF.md
# Per-Pipe Buffer-Empty Interrupt Controller

This block holds one status bit per pipe that records two kinds of event: a transmit pipe whose FIFO has drained at the end of a transmission, and a receive pipe that has taken in a packet longer than its maximum packet size. The transfer engine supplies per-pipe event strobes together with the qualifiers that cancel some of them: a buffer clear, a double-buffer refill, a control status stage, a receive error and a setup transaction. The block qualifies each strobe and sets the matching status bit on the next clock edge.

Software reads the status through a 16-bit view. Only bits 9 to 0 are populated. Software clears a bit by writing 0 to it, and writing 1 leaves a bit unchanged. A per-pipe enable mask gates the status into a combinational summary flag and into a registered active-low interrupt pin. A qualified receive overrun also sends a one-cycle STALL request to the pipe. That request sets the pipe's response ID to 2'b11 and discards the received data. In device mode the block also raises a one-cycle request to answer with a STALL handshake.

Top module: `bufempty_irq_ctrl`

## Requirements
- R1: The read view `status_o` is 16 bits wide. Bit i (0 to 9) is the status of pipe i, and bits 15 to 10 always read 0.
- R2: On a write (`wr_en`=1), a status bit whose `wr_data` bit is 0 is cleared on that edge. A bit whose `wr_data` bit is 1 keeps its value.
- R3: `tx_empty` or `tx_zlp` on pipe i sets status bit i on the next rising edge when no qualifier cancels the event. A single-buffer pipe sees no extra delay.
- R4: A transmit event is ignored on a pipe with `dbl_buf`=1 when `refill_start` is 1 for that pipe in the same cycle.
- R5: A transmit event is ignored on a pipe whose `buf_clear` is 1 in the same cycle.
- R6: When `host_mode`=0 and `ctl_status_stage`=1, transmit events on pipe 0 are ignored.
- R7: `rx_oversize` on pipe i sets status bit i. At the same edge it raises `stall_req[i]` for exactly one cycle, which sets the pipe's response ID to 2'b11 and discards the data.
- R8: `rx_oversize` is ignored when `rx_error` or `setup_busy` is 1 for that pipe in the same cycle. In that case neither the status bit nor the STALL request changes.
- R9: `stall_hs[i]` pulses together with `stall_req[i]` only when `host_mode`=0. In host mode it stays 0, and no response is sent.
- R10: When a qualified event and a write of 0 hit the same bit in the same cycle, the bit ends up 1.
- R11: `irq_flag` is 1 exactly when some status bit and its `irq_en` bit are both 1, and it follows the current status and mask.
- R12: `irq_n` is registered. It equals the inverse of the previous cycle's `irq_flag`, so it drops one cycle after an enabled bit sets and rises one cycle after the last enabled bit clears.
- R13: During and right after reset the status is 0, `irq_n` is 1, and `stall_req` and `stall_hs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| ctl_status_stage | input | 1 | Control transfer is in its IN status stage |
| dbl_buf | input | 10 | Pipe configured for double buffering |
| tx_empty | input | 10 | Transmission finished with FIFO empty |
| tx_zlp | input | 10 | Zero-length packet transmitted |
| refill_start | input | 10 | CPU/DMA began filling the other buffer |
| buf_clear | input | 10 | Explicit or automatic buffer clear |
| rx_oversize | input | 10 | Good packet longer than max packet size |
| rx_error | input | 10 | CRC or bit-stuffing error on this reception |
| setup_busy | input | 10 | Setup transaction in progress |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 10 | Write data: 0 clears, 1 keeps |
| irq_en | input | 10 | Per-pipe interrupt enable mask |
| status_o | output | 16 | Status read view |
| irq_flag | output | 1 | Summary of enabled status bits |
| irq_n | output | 1 | Registered active-low interrupt pin |
| stall_req | output | 10 | One-cycle request to set PID to STALL and discard the data |
| stall_hs | output | 10 | One-cycle request for a STALL handshake (device mode) |

## Verification
The checker watches several rules on every edge: the upper bits stay zero, a bit never drops without a write of 0, a qualified set always lands, a STALL request always comes with its status bit, the pin follows the previous summary, and a cleared buffer never produces a transmit event. Other rules show only in the bench's scenarios. These are the suppression cases for double-buffer refill, the device-mode status stage and a bad or setup reception, and the mode split of the STALL handshake. The bench checks each of them with directed stimulus and then with long random traffic against its own model.

// File: rtl/bemp_pkg.sv
package bemp_pkg;
  localparam int unsigned STATUS_W = 16;

  function automatic logic tx_qualify(input logic empty_done, input logic zlp_done,
                                      input logic clr, input logic dbl, input logic refill,
                                      input logic is_dcp, input logic host, input logic stat_stg);
    logic cancel;
    cancel = clr | (dbl & refill) | (is_dcp & ~host & stat_stg);
    return (empty_done | zlp_done) & ~cancel;
  endfunction

  function automatic logic rx_qualify(input logic oversize, input logic err, input logic setup);
    return oversize & ~err & ~setup;
  endfunction

  function automatic logic next_bit(input logic cur, input logic wr, input logic keep,
                                    input logic set);
    return set | (cur & (~wr | keep));
  endfunction
endpackage

// File: rtl/bemp_qualify.sv
module bemp_qualify #(
  parameter int unsigned N = 10
) (
  input  logic         host_mode,
  input  logic         ctl_status_stage,
  input  logic [N-1:0] dbl_buf,
  input  logic [N-1:0] tx_empty,
  input  logic [N-1:0] tx_zlp,
  input  logic [N-1:0] refill_start,
  input  logic [N-1:0] buf_clear,
  input  logic [N-1:0] rx_oversize,
  input  logic [N-1:0] rx_error,
  input  logic [N-1:0] setup_busy,
  output logic [N-1:0] tx_evt,
  output logic [N-1:0] rx_evt
);
  import bemp_pkg::*;

  for (genvar p = 0; p < N; p++) begin : g_pipe
    localparam logic IS_DCP = (p == 0);
    assign tx_evt[p] = tx_qualify(tx_empty[p], tx_zlp[p], buf_clear[p], dbl_buf[p],
                                  refill_start[p], IS_DCP, host_mode, ctl_status_stage);
    assign rx_evt[p] = rx_qualify(rx_oversize[p], rx_error[p], setup_busy[p]);
  end
endmodule

// File: rtl/bemp_status_reg.sv
module bemp_status_reg #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         wr_en,
  input  logic [N-1:0] wr_keep,
  output logic [N-1:0] status_q
);
  import bemp_pkg::*;

  logic [N-1:0] status_d;

  for (genvar p = 0; p < N; p++) begin : g_bit
    assign status_d[p] = next_bit(status_q[p], wr_en, wr_keep[p], set_vec[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/bemp_irq_out.sv
module bemp_irq_out #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] status,
  input  logic [N-1:0] enable,
  output logic         flag,
  output logic         pin_n
);
  assign flag = |(status & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_n <= 1'b1;
    else        pin_n <= ~flag;
  end
endmodule

// File: rtl/bufempty_irq_ctrl.sv
module bufempty_irq_ctrl #(
  parameter int unsigned NUM_PIPES = 10,
  parameter int unsigned REG_W     = bemp_pkg::STATUS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_mode,
  input  logic                 ctl_status_stage,
  input  logic [NUM_PIPES-1:0] dbl_buf,
  input  logic [NUM_PIPES-1:0] tx_empty,
  input  logic [NUM_PIPES-1:0] tx_zlp,
  input  logic [NUM_PIPES-1:0] refill_start,
  input  logic [NUM_PIPES-1:0] buf_clear,
  input  logic [NUM_PIPES-1:0] rx_oversize,
  input  logic [NUM_PIPES-1:0] rx_error,
  input  logic [NUM_PIPES-1:0] setup_busy,
  input  logic                 wr_en,
  input  logic [NUM_PIPES-1:0] wr_data,
  input  logic [NUM_PIPES-1:0] irq_en,
  output logic [REG_W-1:0]     status_o,
  output logic                 irq_flag,
  output logic                 irq_n,
  output logic [NUM_PIPES-1:0] stall_req,
  output logic [NUM_PIPES-1:0] stall_hs
);
  localparam int unsigned PAD_W = REG_W - NUM_PIPES;

  logic [NUM_PIPES-1:0] tx_evt;
  logic [NUM_PIPES-1:0] rx_evt;
  logic [NUM_PIPES-1:0] set_vec;
  logic [NUM_PIPES-1:0] status_q;

  bemp_qualify #(.N(NUM_PIPES)) u_qual (
    .host_mode        (host_mode),
    .ctl_status_stage (ctl_status_stage),
    .dbl_buf          (dbl_buf),
    .tx_empty         (tx_empty),
    .tx_zlp           (tx_zlp),
    .refill_start     (refill_start),
    .buf_clear        (buf_clear),
    .rx_oversize      (rx_oversize),
    .rx_error         (rx_error),
    .setup_busy       (setup_busy),
    .tx_evt           (tx_evt),
    .rx_evt           (rx_evt)
  );

  assign set_vec = tx_evt | rx_evt;

  bemp_status_reg #(.N(NUM_PIPES)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .wr_en    (wr_en),
    .wr_keep  (wr_data),
    .status_q (status_q)
  );

  bemp_irq_out #(.N(NUM_PIPES)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_q),
    .enable (irq_en),
    .flag   (irq_flag),
    .pin_n  (irq_n)
  );

  // Overrun reaction: PID forced to STALL (2'b11) and data dropped; handshake only as device
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_req <= '0;
      stall_hs  <= '0;
    end else begin
      stall_req <= rx_evt;
      stall_hs  <= host_mode ? '0 : rx_evt;
    end
  end

  if (PAD_W > 0) begin : g_pad
    assign status_o = {{PAD_W{1'b0}}, status_q};
  end else begin : g_nopad
    assign status_o = status_q[REG_W-1:0];
  end
endmodule

// File: rtl/bemp_checker.sv
module bemp_checker #(
  parameter int unsigned N = 10,
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] buf_clear,
  input logic [N-1:0] rx_oversize,
  input logic         wr_en,
  input logic [N-1:0] wr_data,
  input logic [N-1:0] irq_en,
  input logic [W-1:0] status_o,
  input logic         irq_flag,
  input logic         irq_n,
  input logic [N-1:0] stall_req,
  input logic [N-1:0] tx_evt,
  input logic [N-1:0] set_vec
);
  logic [N-1:0] st;
  assign st = status_o[N-1:0];

  // R1
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o >> N) == '0);

  // R2: bits written with 1 never drop
  a_r2_keep_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (($past(st) & $past(wr_data) & ~st) == '0));

  // R2: without a write nothing drops
  a_r2_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (($past(st) & ~st) == '0));

  // R10: a qualified set always lands
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((st & $past(set_vec)) == $past(set_vec)));

  // R7: STALL request only with its status bit
  a_r7_stall_has_status: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req & ~st) == '0);

  // R5: a cleared buffer yields no transmit event
  a_r5_clear_blocks_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_clear & tx_evt) == '0);

  // R12
  a_r12_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == !$past(irq_flag)));

  // R11
  a_r11_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag == ((st & irq_en) != '0));

  // R8: a qualified set needs a tx event or an overrun strobe
  a_r8_set_source: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec & ~tx_evt & ~rx_oversize) == '0);
endmodule

bind bufempty_irq_ctrl bemp_checker #(.N(NUM_PIPES), .W(REG_W)) u_bemp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .buf_clear   (buf_clear),
  .rx_oversize (rx_oversize),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .irq_en      (irq_en),
  .status_o    (status_o),
  .irq_flag    (irq_flag),
  .irq_n       (irq_n),
  .stall_req   (stall_req),
  .tx_evt      (tx_evt),
  .set_vec     (set_vec)
);

// File: tb/test_bufempty_irq_ctrl.sv
`timescale 1ns/1ps
module test_bufempty_irq_ctrl;
  localparam int N = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode, ctl_status_stage, wr_en;
  logic [N-1:0] dbl_buf, tx_empty, tx_zlp, refill_start, buf_clear;
  logic [N-1:0] rx_oversize, rx_error, setup_busy, wr_data, irq_en;
  logic [W-1:0] status_o;
  logic irq_flag, irq_n;
  logic [N-1:0] stall_req, stall_hs;

  int n_chk = 0;
  int n_fail = 0;
  logic [N-1:0] m_st = '0;
  logic [N-1:0] m_stall = '0;
  logic [N-1:0] m_hs = '0;
  logic m_pin = 1'b1;

  always #2 clk = ~clk;

  bufempty_irq_ctrl i_bufempty_irq_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_set();
    logic [N-1:0] s;
    for (int p = 0; p < N; p++) begin
      logic tx, rx;
      tx = (tx_empty[p] | tx_zlp[p]) && !buf_clear[p] && !(dbl_buf[p] && refill_start[p])
           && !(p == 0 && !host_mode && ctl_status_stage);
      rx = rx_oversize[p] && !rx_error[p] && !setup_busy[p];
      s[p] = tx | rx;
    end
    return s;
  endfunction

  function automatic logic [N-1:0] exp_rx();
    return rx_oversize & ~rx_error & ~setup_busy;
  endfunction

  task automatic idle();
    host_mode = 1'b0; ctl_status_stage = 1'b0; wr_en = 1'b0;
    dbl_buf = '0; tx_empty = '0; tx_zlp = '0; refill_start = '0; buf_clear = '0;
    rx_oversize = '0; rx_error = '0; setup_busy = '0; wr_data = '1;
  endtask

  // advance one edge with the inputs currently driven, update model, compare
  task automatic step(input string req);
    logic [N-1:0] keep;
    keep  = wr_en ? wr_data : '1;
    m_pin = ~|(m_st & irq_en);
    m_stall = exp_rx();
    m_hs  = host_mode ? '0 : exp_rx();
    m_st  = (m_st & keep) | exp_set();
    @(posedge clk);
    @(negedge clk);
    chk({req, " status"}, 32'(status_o), 32'(m_st));
    chk({req, " stall_req"}, 32'(stall_req), 32'(m_stall));
    chk({req, " stall_hs"}, 32'(stall_hs), 32'(m_hs));
    chk({req, " irq_n"}, 32'(irq_n), 32'(m_pin));
    chk({req, " irq_flag"}, 32'(irq_flag), 32'(|(m_st & irq_en)));
  endtask

  task automatic clear_all();
    idle(); wr_en = 1'b1; wr_data = '0; step("R2 clear all"); idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle(); irq_en = '1;
    repeat (3) @(negedge clk);
    chk("R13 status in reset", 32'(status_o), 0);
    chk("R13 irq_n in reset", 32'(irq_n), 1);
    chk("R13 stall in reset", 32'(stall_req | stall_hs), 0);
    rst_n = 1'b1;
    step("R13 idle");

    // R3 single tx event, pipe 4, then irq pin one cycle later (R12)
    tx_empty[4] = 1'b1; step("R3 tx_empty");
    idle(); step("R12 pin low");
    chk("R1 upper bits", 32'(status_o[W-1:N]), 0);
    tx_zlp[9] = 1'b1; step("R3 zlp"); idle();
    // R2 clear pipe 4 only by writing 0 there, 1 elsewhere
    wr_en = 1'b1; wr_data = ~(N'(1) << 4); step("R2 clear one");
    idle();
    wr_en = 1'b1; wr_data = '1; step("R2 write ones keeps");
    idle(); clear_all(); step("R12 pin release");

    // R4 refill suppression vs single-buffer
    dbl_buf[2] = 1'b1; refill_start[2] = 1'b1; tx_empty[2] = 1'b1; step("R4 refill");
    idle(); refill_start[3] = 1'b1; tx_empty[3] = 1'b1; step("R4 single buf not cancelled");
    chk("R4 pipe2 untouched", 32'(status_o[2]), 0);
    clear_all();
    // R5 buffer clear
    buf_clear[5] = 1'b1; tx_empty[5] = 1'b1; tx_zlp[6] = 1'b1; buf_clear[6] = 1'b1;
    step("R5 buf_clear"); idle();
    chk("R5 no status", 32'(status_o), 0);
    // R6 device status stage on pipe 0; host mode not suppressed
    ctl_status_stage = 1'b1; tx_zlp[0] = 1'b1; tx_zlp[1] = 1'b1; step("R6 device status stage");
    chk("R6 pipe0 untouched", 32'(status_o[0]), 0);
    host_mode = 1'b1; step("R6 host status stage");
    clear_all();
    // R7/R9 device overrun, R9 host overrun
    rx_oversize[7] = 1'b1; step("R7 R9 device overrun");
    idle(); step("R7 pulse ends");
    host_mode = 1'b1; rx_oversize[8] = 1'b1; step("R9 host overrun no handshake");
    idle(); clear_all();
    // R8 error / setup cancel
    rx_oversize[1] = 1'b1; rx_error[1] = 1'b1; rx_oversize[2] = 1'b1; setup_busy[2] = 1'b1;
    step("R8 cancelled overrun");
    chk("R8 no stall", 32'(stall_req), 0);
    idle();
    // R10 set beats clear
    tx_empty[3] = 1'b1; wr_en = 1'b1; wr_data = '0; step("R10 set vs clear");
    chk("R10 bit kept", 32'(status_o[3]), 1);
    idle();
    // R11 mask
    irq_en = '0; step("R11 masked"); chk("R11 flag low", 32'(irq_flag), 0);
    irq_en = N'(1) << 3; step("R11 enabled");
    chk("R11 flag high", 32'(irq_flag), 1);
    clear_all();

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      idle();
      host_mode = ($urandom % 4) == 0;
      ctl_status_stage = ($urandom % 3) == 0;
      dbl_buf = N'($urandom);
      irq_en = N'($urandom);
      for (int p = 0; p < N; p++) begin
        tx_empty[p]     = ($urandom % 12) == 0;
        tx_zlp[p]       = ($urandom % 20) == 0;
        refill_start[p] = ($urandom % 3) == 0;
        buf_clear[p]    = ($urandom % 6) == 0;
        rx_oversize[p]  = ($urandom % 15) == 0;
        rx_error[p]     = ($urandom % 3) == 0;
        setup_busy[p]   = ($urandom % 4) == 0;
      end
      wr_en = ($urandom % 5) == 0;
      wr_data = N'($urandom) | N'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule